// File: doc/BRIEF.md
# ADC sample-and-convert timing controller

This block is the digital sequencer in front of a successive-approximation converter core. It picks one of eight trigger sources, can invert it, and turns a rising edge of the conditioned level into one sample-and-convert cycle. The sampling-control output is timed in one of two ways. In pulse mode an internal counter sets the sample period. In extended mode the trigger level sets it directly. After the sample period a short settle phase runs, then a conversion phase whose length depends on the selected resolution. A one-cycle done strobe closes the cycle.

All timing counts advance only on system clocks where the ADC clock enable is high. The block also drives power control. It requests the reference buffer only when the selected reference code needs it, and it keeps the core and its oscillator enabled only while there is work to do. When the buffer is powered down between conversions, pulse mode holds the sample period back until the reference reports ready. Configuration inputs are assumed static while `busy` is high.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `trig_sel` = 0 selects `sw_start`, and `trig_sel` = k (1..7) selects `ext_trig[k-1]`. `trig_inv` = 1 inverts the selected level before edge detection. Only a rising edge of the conditioned level starts a cycle, and unselected sources have no effect.
- R2: The cycle starts on the second rising clock edge after the conditioned level first reads high. That edge raises `busy`, and also raises `samp_ctl` unless the cycle waits for the reference (R10).
- R3: In pulse mode (`pulse_mode` = 1), `samp_ctl` stays high for 4, 8, 16, 32, 64, 96, 128 or 192 enabled ticks for `smp_sel` codes 0 to 7, whatever the trigger level does.
- R4: In extended mode (`pulse_mode` = 0), `samp_ctl` stays high until the second clock edge after the conditioned level goes low, so its width equals the trigger width.
- R5: After `samp_ctl` falls, the conversion phase begins after 1 enabled tick in pulse mode, or after 3 enabled ticks in extended mode (a two-stage synchronisation plus one tick).
- R6: The conversion phase lasts 10, 12 or 14 enabled ticks for `res_sel` = 0 (8-bit), 1 (10-bit) or 2 (12-bit). Code 3 behaves as code 2.
- R7: `conv_done` is high for exactly one clock, on the edge that ends the last conversion tick. `busy` falls on that same edge. After reset all outputs are low.
- R8: A rising edge that arrives while `busy` is high starts nothing and sets the sticky `ovf`. `ovf_clr` = 1 clears `ovf`, and a new set in the same cycle wins over the clear.
- R9: `ref_req` = `ref_sel[0]` AND (`ref_on` OR `busy` OR keep). Keep is true when `ref_out` = 1, or when pulse mode is used with `multi_smp` = 1, or when `seq_mode` ≠ 0.
- R10: In pulse mode, if `ref_sel[0]` = 1, `ref_on` = 0, keep is false and `ref_rdy` = 0 at the start edge, the block waits with `busy` and `osc_req` high and `samp_ctl` and `core_en` low. On the first edge where `ref_rdy` = 1 it enters the sample period. Extended mode never waits.
- R11: `core_en` is high exactly during the sample, settle and conversion phases. `osc_req` is high whenever `busy` is high.
- R12: No sample, settle or conversion count advances on a clock where `adc_ce` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_ce | input | 1 | ADC clock enable, one tick per high cycle |
| sw_start | input | 1 | Software start, trigger source 0 |
| ext_trig | input | 7 | External trigger sources 1 to 7 |
| trig_sel | input | 3 | Trigger source select |
| trig_inv | input | 1 | Invert the selected trigger level |
| pulse_mode | input | 1 | 1 = pulse sampling, 0 = extended sampling |
| smp_sel | input | 3 | Pulse-mode sample length code |
| res_sel | input | 2 | Resolution code |
| ref_on | input | 1 | Keep reference requested continuously |
| ref_out | input | 1 | Reference driven out, buffer kept on |
| multi_smp | input | 1 | Multiple-sample mode, keeps the buffer on in pulse mode |
| seq_mode | input | 2 | Sequence mode, 0 = single channel single conversion |
| ref_sel | input | 4 | Reference select code, odd codes use the local buffer |
| ref_rdy | input | 1 | Reference buffer settled |
| ovf_clr | input | 1 | Write-one clear of `ovf` |
| samp_ctl | output | 1 | Sampling control to the core |
| core_en | output | 1 | Converter core enable |
| osc_req | output | 1 | Conversion oscillator request |
| ref_req | output | 1 | Reference and buffer request |
| busy | output | 1 | A cycle is in progress |
| conv_done | output | 1 | One-clock conversion-complete strobe |
| ovf | output | 1 | Sticky trigger overflow flag |

## Verification
Every result has a fixed due cycle. `busy` and `samp_ctl` rise two clock edges after the trigger level changes. `samp_ctl` falls two edges after the level drops in extended mode, or after the programmed tick count in pulse mode. `conv_done` follows the fall of `samp_ctl` by 1 + N or 3 + N enabled ticks, and `ovf` changes on the edge after the offending trigger is seen. A behavioural model in the bench advances on each rising edge from the same inputs, and every output is compared one step after the falling edge, when inputs and combinational paths have settled. Directed tasks count falling edges from a stimulus to the output change and compare that count with the figures above. They also cover a stalled clock enable and a wait for the reference.

// File: rtl/adc_seq_pkg.sv
// Package: shared state encoding and timing tables for the sample/convert
// sequencer. Assumes the tables are read only with legal code widths.
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WREF = 3'd1,
        ST_SAMP = 3'd2,
        ST_SETL = 3'd3,
        ST_CONV = 3'd4
    } seq_state_t;

    // Pulse-mode sample period in ADC ticks for each 3-bit code.
    function automatic int smp_ticks(input logic [2:0] code);
        case (code)
            3'd0:    return 4;
            3'd1:    return 8;
            3'd2:    return 16;
            3'd3:    return 32;
            3'd4:    return 64;
            3'd5:    return 96;
            3'd6:    return 128;
            default: return 192;
        endcase
    endfunction

    // Conversion phase length in ADC ticks for each resolution code.
    function automatic int conv_ticks(input logic [1:0] res);
        case (res)
            2'd0:    return 10;
            2'd1:    return 12;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/adc_seq_trig.sv
// Trigger conditioner: selects one of N_SRC sources, applies the polarity
// bit, registers the level twice and flags a rising edge. Assumes the
// sources are already synchronous to clk.
module adc_seq_trig #(
    parameter int N_SRC = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_start,
    input  logic [N_SRC-2:0] ext_trig,
    input  logic [SEL_W-1:0] trig_sel,
    input  logic             trig_inv,
    output logic             lvl,
    output logic             rise
);

    logic [N_SRC-1:0] src_vec;
    logic             cond_lvl;
    logic             lvl_q;
    logic             lvl_qq;

    // Source vector with the software bit in slot 0.
    always_comb begin
        src_vec  = {ext_trig, sw_start};
        cond_lvl = src_vec[trig_sel] ^ trig_inv;
    end

    // Two-stage level history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            lvl_qq <= 1'b0;
        end else begin
            lvl_q  <= cond_lvl;
            lvl_qq <= lvl_q;
        end
    end

    // Rising edge seen between the two history stages.
    always_comb begin
        lvl  = lvl_q;
        rise = lvl_q & ~lvl_qq;
    end

endmodule

// File: rtl/adc_seq_pwr.sv
// Power gating: derives the reference request, core enable, oscillator
// request and the pulse-mode reference wait condition from the sequencer
// state and the static configuration.
module adc_seq_pwr
    import adc_seq_pkg::*;
#(
    parameter int REF_W = 4
) (
    input  seq_state_t       state,
    input  logic [REF_W-1:0] ref_sel,
    input  logic             ref_on,
    input  logic             ref_out,
    input  logic             pulse_mode,
    input  logic             multi_smp,
    input  logic [1:0]       seq_mode,
    output logic             ref_req,
    output logic             core_en,
    output logic             osc_req,
    output logic             need_wait
);

    localparam logic [REF_W-1:0] BUF_MASK = REF_W'(1);

    logic buf_used;
    logic buf_keep;
    logic active;

    // Decide whether the local buffer is used and whether it stays powered.
    always_comb begin
        buf_used  = |(ref_sel & BUF_MASK);
        buf_keep  = ref_out | (pulse_mode & multi_smp) | (seq_mode != 2'd0);
        active    = (state != ST_IDLE);
        need_wait = buf_used & ~ref_on & ~buf_keep;
    end

    // Drive the power requests.
    always_comb begin
        ref_req = buf_used & (ref_on | buf_keep | active);
        core_en = (state == ST_SAMP) | (state == ST_SETL) | (state == ST_CONV);
        osc_req = active;
    end

endmodule

// File: rtl/adc_seq_fsm.sv
// Phase sequencer: idle, reference wait, sample, settle, convert. Every
// count advances only on adc_ce. Also drives the done strobe and the
// sticky overflow flag. Assumes configuration is static while busy.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adc_ce,
    input  logic       rise,
    input  logic       lvl,
    input  logic       pulse_mode,
    input  logic [2:0] smp_sel,
    input  logic [1:0] res_sel,
    input  logic       need_wait,
    input  logic       ref_rdy,
    input  logic       ovf_clr,
    output seq_state_t state,
    output logic       conv_done,
    output logic       ovf
);

    localparam logic [CNT_W-1:0] EXT_LAST = CNT_W'(SYNC_STAGES);

    seq_state_t       state_nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] last;
    logic             done_nxt;
    logic             ovf_nxt;
    logic             at_last;

    // Terminal count of the current phase.
    always_comb begin
        case (state)
            ST_SAMP: last = CNT_W'(smp_ticks(smp_sel) - 1);
            ST_SETL: last = pulse_mode ? '0 : EXT_LAST;
            ST_CONV: last = CNT_W'(conv_ticks(res_sel) - 1);
            default: last = '0;
        endcase
        at_last = adc_ce && (cnt == last);
    end

    // Next phase and counter value.
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        done_nxt  = 1'b0;
        case (state)
            ST_IDLE: begin
                cnt_nxt = '0;
                if (rise) begin
                    if (pulse_mode && need_wait && !ref_rdy) state_nxt = ST_WREF;
                    else                                      state_nxt = ST_SAMP;
                end
            end
            ST_WREF: begin
                cnt_nxt = '0;
                if (ref_rdy) state_nxt = ST_SAMP;
            end
            ST_SAMP: begin
                if (!pulse_mode) begin
                    if (!lvl) begin
                        state_nxt = ST_SETL;
                        cnt_nxt   = '0;
                    end
                end else if (at_last) begin
                    state_nxt = ST_SETL;
                    cnt_nxt   = '0;
                end else if (adc_ce) begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            ST_SETL: begin
                if (at_last) begin
                    state_nxt = ST_CONV;
                    cnt_nxt   = '0;
                end else if (adc_ce) begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            ST_CONV: begin
                if (at_last) begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                    done_nxt  = 1'b1;
                end else if (adc_ce) begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // Overflow: a set from a trigger while busy wins over the clear.
    always_comb begin
        if (rise && (state != ST_IDLE)) ovf_nxt = 1'b1;
        else if (ovf_clr)               ovf_nxt = 1'b0;
        else                            ovf_nxt = ovf;
    end

    // State, counter, strobe and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            conv_done <= 1'b0;
            ovf       <= 1'b0;
        end else begin
            state     <= state_nxt;
            cnt       <= cnt_nxt;
            conv_done <= done_nxt;
            ovf       <= ovf_nxt;
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the ADC sample-and-convert timing controller. Wires the trigger
// conditioner, the phase sequencer and the power gating together.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int N_SRC       = 8,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int REF_W       = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adc_ce,
    input  logic                     sw_start,
    input  logic [N_SRC-2:0]         ext_trig,
    input  logic [$clog2(N_SRC)-1:0] trig_sel,
    input  logic                     trig_inv,
    input  logic                     pulse_mode,
    input  logic [2:0]               smp_sel,
    input  logic [1:0]               res_sel,
    input  logic                     ref_on,
    input  logic                     ref_out,
    input  logic                     multi_smp,
    input  logic [1:0]               seq_mode,
    input  logic [REF_W-1:0]         ref_sel,
    input  logic                     ref_rdy,
    input  logic                     ovf_clr,
    output logic                     samp_ctl,
    output logic                     core_en,
    output logic                     osc_req,
    output logic                     ref_req,
    output logic                     busy,
    output logic                     conv_done,
    output logic                     ovf
);

    localparam int SEL_W = $clog2(N_SRC);

    logic       lvl;
    logic       rise;
    logic       need_wait;
    seq_state_t state;

    adc_seq_trig #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_start (sw_start),
        .ext_trig (ext_trig),
        .trig_sel (trig_sel),
        .trig_inv (trig_inv),
        .lvl      (lvl),
        .rise     (rise)
    );

    adc_seq_fsm #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .adc_ce     (adc_ce),
        .rise       (rise),
        .lvl        (lvl),
        .pulse_mode (pulse_mode),
        .smp_sel    (smp_sel),
        .res_sel    (res_sel),
        .need_wait  (need_wait),
        .ref_rdy    (ref_rdy),
        .ovf_clr    (ovf_clr),
        .state      (state),
        .conv_done  (conv_done),
        .ovf        (ovf)
    );

    adc_seq_pwr #(.REF_W(REF_W)) u_pwr (
        .state      (state),
        .ref_sel    (ref_sel),
        .ref_on     (ref_on),
        .ref_out    (ref_out),
        .pulse_mode (pulse_mode),
        .multi_smp  (multi_smp),
        .seq_mode   (seq_mode),
        .ref_req    (ref_req),
        .core_en    (core_en),
        .osc_req    (osc_req),
        .need_wait  (need_wait)
    );

    // Port-level views of the sequencer state.
    always_comb begin
        busy     = (state != ST_IDLE);
        samp_ctl = (state == ST_SAMP);
    end

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Checker for adc_seq_ctrl: port-level temporal properties, bound to the top.
module adc_seq_ctrl_chk #(
    parameter int REF_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             samp_ctl,
    input logic             core_en,
    input logic             osc_req,
    input logic             ref_req,
    input logic             busy,
    input logic             conv_done,
    input logic             ovf,
    input logic             ovf_clr,
    input logic [REF_W-1:0] ref_sel
);

    // R11: the core is never enabled outside a cycle
    a_r11_core_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> (busy && osc_req));

    // R3: sampling happens only with the core enabled
    a_r3_samp_core_on: assert property (@(posedge clk) disable iff (!rst_n)
        samp_ctl |-> core_en);

    // R7: the done strobe lasts a single clock
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);

    // R7: the done strobe coincides with the end of busy
    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> (!busy && $past(busy)));

    // R8: overflow is sticky until cleared
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    // R8: overflow only rises during a cycle
    a_r8_ovf_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(busy));

    // R9: an odd reference code is requested throughout a cycle
    a_r9_ref_during_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ref_sel[0]) |-> ref_req);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.REF_W(REF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_ctl  (samp_ctl),
    .core_en   (core_en),
    .osc_req   (osc_req),
    .ref_req   (ref_req),
    .busy      (busy),
    .conv_done (conv_done),
    .ovf       (ovf),
    .ovf_clr   (ovf_clr),
    .ref_sel   (ref_sel)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adc_ce = 1'b1;
    logic       sw_start = 1'b0;
    logic [6:0] ext_trig = '0;
    logic [2:0] trig_sel = '0;
    logic       trig_inv = 1'b0;
    logic       pulse_mode = 1'b1;
    logic [2:0] smp_sel = '0;
    logic [1:0] res_sel = '0;
    logic       ref_on = 1'b0;
    logic       ref_out = 1'b0;
    logic       multi_smp = 1'b0;
    logic [1:0] seq_mode = '0;
    logic [3:0] ref_sel = '0;
    logic       ref_rdy = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       samp_ctl, core_en, osc_req, ref_req, busy, conv_done, ovf;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .adc_ce(adc_ce), .sw_start(sw_start),
        .ext_trig(ext_trig), .trig_sel(trig_sel), .trig_inv(trig_inv),
        .pulse_mode(pulse_mode), .smp_sel(smp_sel), .res_sel(res_sel),
        .ref_on(ref_on), .ref_out(ref_out), .multi_smp(multi_smp),
        .seq_mode(seq_mode), .ref_sel(ref_sel), .ref_rdy(ref_rdy),
        .ovf_clr(ovf_clr), .samp_ctl(samp_ctl), .core_en(core_en),
        .osc_req(osc_req), .ref_req(ref_req), .busy(busy),
        .conv_done(conv_done), .ovf(ovf)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_st = 0;      // 0 idle, 1 wait ref, 2 sample, 3 settle, 4 convert
    int m_left = 0;
    bit m_l1 = 0, m_l2 = 0, m_ovf = 0, m_done = 0;

    function automatic int tab_smp(input int c);
        int t[8] = '{4, 8, 16, 32, 64, 96, 128, 192};
        return t[c];
    endfunction

    function automatic bit cur_level();
        bit b;
        b = (trig_sel == 0) ? sw_start : ext_trig[trig_sel - 1];
        return b ^ trig_inv;
    endfunction

    function automatic bit keep_on();
        return ref_out || (pulse_mode && multi_smp) || (seq_mode != 0);
    endfunction

    always @(posedge clk) begin
        bit rise, lvl_old, gw;
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_left = 0; m_l1 = 0; m_l2 = 0; m_ovf = 0; m_done = 0;
        end else begin
            lvl_old = m_l1;
            rise = m_l1 && !m_l2;
            m_l2 = m_l1;
            m_l1 = cur_level();
            gw = ref_sel[0] && !ref_on && !keep_on();
            if (rise && m_st != 0) m_ovf = 1;
            else if (ovf_clr) m_ovf = 0;
            m_done = 0;
            case (m_st)
                0: if (rise) begin
                       if (pulse_mode && gw && !ref_rdy) m_st = 1;
                       else begin m_st = 2; m_left = tab_smp(int'(smp_sel)); end
                   end
                1: if (ref_rdy) begin m_st = 2; m_left = tab_smp(int'(smp_sel)); end
                2: if (pulse_mode) begin
                       if (adc_ce) begin
                           m_left--;
                           if (m_left == 0) begin m_st = 3; m_left = 1; end
                       end
                   end else if (!lvl_old) begin m_st = 3; m_left = 3; end
                3: if (adc_ce) begin
                       m_left--;
                       if (m_left == 0) begin
                           m_st = 4;
                           m_left = 10 + 2 * ((res_sel > 2) ? 2 : int'(res_sel));
                       end
                   end
                default: if (adc_ce) begin
                       m_left--;
                       if (m_left == 0) begin m_st = 0; m_done = 1; end
                   end
            endcase
        end
    end

    // Compare every output one step after the falling edge.
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !done_flag) begin
            chk("R3/R4 samp_ctl", samp_ctl, m_st == 2);
            chk("R7 busy", busy, m_st != 0);
            chk("R11 core_en", core_en, m_st >= 2);
            chk("R11 osc_req", osc_req, m_st != 0);
            chk("R9 ref_req", ref_req, ref_sel[0] && (ref_on || keep_on() || m_st != 0));
            chk("R6 conv_done", conv_done, m_done);
            chk("R8 ovf", ovf, m_ovf);
        end
    end

    // ---------------- directed helpers ----------------
    task automatic wait_idle();
        int lim = 0;
        while ((busy || samp_ctl) && lim < 2000) begin @(negedge clk); lim++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic measure(output int w, output int g);
        int lim = 0;
        w = 0; g = 0;
        while (!samp_ctl && lim < 2000) begin @(negedge clk); lim++; end
        while (samp_ctl && w < 2000) begin @(negedge clk); w++; end
        while (!conv_done && g < 2000) begin @(negedge clk); g++; end
    endtask

    task automatic pulse_run(input int code, input int res, input int ew, input int eg);
        int w, g;
        @(negedge clk);
        pulse_mode = 1; smp_sel = code[2:0]; res_sel = res[1:0];
        fork
            measure(w, g);
            begin @(negedge clk); sw_start = 1; repeat (3) @(negedge clk); sw_start = 0; end
        join
        chk("R3 pulse sample width", w, ew);
        chk("R5/R6 pulse fall-to-done", g, eg);
        wait_idle();
    endtask

    task automatic ext_run(input int h, input int res, input int eg);
        int w, g;
        @(negedge clk);
        pulse_mode = 0; res_sel = res[1:0];
        fork
            measure(w, g);
            begin @(negedge clk); sw_start = 1; repeat (h) @(negedge clk); sw_start = 0; end
        join
        chk("R4 extended sample width", w, h);
        chk("R5/R6 extended fall-to-done", g, eg);
        wait_idle();
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (4) @(negedge clk);
        chk("R7 reset busy", busy, 0);
        chk("R7 reset samp_ctl", samp_ctl, 0);
        chk("R7 reset conv_done", conv_done, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // R2: start latency from the software bit
        sw_start = 1;
        @(negedge clk); chk("R2 not yet busy", busy, 0);
        @(negedge clk); chk("R2 busy on second edge", busy, 1);
        chk("R2 samp_ctl on second edge", samp_ctl, 1);
        sw_start = 0;
        wait_idle();

        // R3, R5, R6: pulse mode lengths
        pulse_run(0, 0, 4, 11);
        pulse_run(7, 2, 192, 15);
        pulse_run(5, 3, 96, 15);
        pulse_run(2, 1, 16, 13);

        // R4, R5, R6: extended mode
        ext_run(6, 1, 15);
        ext_run(1, 0, 13);

        // R1: source 5 inverted, other sources ignored
        @(negedge clk);
        pulse_mode = 1; smp_sel = 0; res_sel = 0;
        ext_trig = 7'h7f; trig_sel = 3'd5; trig_inv = 1;
        repeat (3) @(negedge clk);
        sw_start = 1; ext_trig[0] = 0;
        repeat (4) @(negedge clk);
        chk("R1 unselected sources ignored", busy, 0);
        sw_start = 0; ext_trig[0] = 1;
        repeat (2) @(negedge clk);
        ext_trig[4] = 0;
        repeat (2) @(negedge clk);
        chk("R1 inverted source 5 starts", busy, 1);
        wait_idle();
        ext_trig = '0; trig_inv = 0; trig_sel = 0;
        repeat (3) @(negedge clk);

        // R12: stalled clock enable freezes the sample count
        adc_ce = 0; smp_sel = 0;
        sw_start = 1;
        repeat (2) @(negedge clk);
        sw_start = 0;
        repeat (40) @(negedge clk);
        chk("R12 sample held while adc_ce low", samp_ctl, 1);
        begin
            int w = 0;
            adc_ce = 1;
            while (samp_ctl && w < 100) begin @(negedge clk); w++; end
            chk("R12 remaining width after enable", w, 4);
        end
        wait_idle();

        // R9: reference request from static configuration
        ref_sel = 4'd1;
        @(negedge clk); chk("R9 idle odd code no keep", ref_req, 0);
        ref_out = 1;
        @(negedge clk); chk("R9 ref_out keeps request", ref_req, 1);
        ref_out = 0; seq_mode = 2;
        @(negedge clk); chk("R9 sequence mode keeps request", ref_req, 1);
        seq_mode = 0; ref_on = 1; ref_sel = 4'd2;
        @(negedge clk); chk("R9 even code never requests", ref_req, 0);
        ref_on = 0; ref_sel = 4'd3;

        // R10: pulse mode waits for reference ready
        ref_rdy = 0;
        sw_start = 1;
        repeat (2) @(negedge clk);
        sw_start = 0;
        chk("R10 waiting is busy", busy, 1);
        chk("R10 waiting keeps oscillator", osc_req, 1);
        chk("R10 no sampling while unready", samp_ctl, 0);
        chk("R10 core off while waiting", core_en, 0);
        repeat (10) @(negedge clk);
        chk("R10 still waiting", samp_ctl, 0);
        ref_rdy = 1;
        @(negedge clk);
        chk("R10 sampling after ready", samp_ctl, 1);
        wait_idle();
        ref_rdy = 0; ref_sel = 0;

        // R8: overflow set while busy, then cleared
        smp_sel = 7;
        sw_start = 1; repeat (2) @(negedge clk); sw_start = 0;
        repeat (10) @(negedge clk);
        chk("R8 no overflow yet", ovf, 0);
        sw_start = 1; repeat (2) @(negedge clk);
        chk("R8 overflow on retrigger", ovf, 1);
        chk("R8 retrigger does not restart", busy, 1);
        sw_start = 0;
        ovf_clr = 1; @(negedge clk); ovf_clr = 0;
        @(negedge clk);
        chk("R8 write-one clear", ovf, 0);
        wait_idle();

        // Random segments, compared every cycle against the model
        for (int seg = 0; seg < 12; seg++) begin
            sw_start = 0; ext_trig = '0; trig_inv = 0; trig_sel = 0;
            wait_idle();
            pulse_mode = seg[0];
            smp_sel    = 3'($urandom_range(0, 3));
            res_sel    = 2'($urandom_range(0, 3));
            ref_sel    = 4'($urandom_range(0, 15));
            ref_on     = ($urandom_range(0, 3) == 0);
            ref_out    = ($urandom_range(0, 3) == 0);
            multi_smp  = $urandom_range(0, 1);
            seq_mode   = ($urandom_range(0, 3) == 0) ? 2'd1 : 2'd0;
            trig_sel   = 3'($urandom_range(0, 7));
            for (int i = 0; i < 1500; i++) begin
                @(negedge clk);
                adc_ce   = ($urandom_range(0, 3) != 0);
                ref_rdy  = ($urandom_range(0, 7) == 0);
                ovf_clr  = ($urandom_range(0, 31) == 0);
                if ($urandom_range(0, 9) == 0) sw_start = ~sw_start;
                if ($urandom_range(0, 9) == 0) ext_trig = 7'($urandom);
            end
            adc_ce = 1; ref_rdy = 1; ovf_clr = 0;
        end

        sw_start = 0; ext_trig = '0;
        wait_idle();
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !done_flag) begin
            done_flag = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule